// File: doc/BRIEF.md
# Packed Integer to Single-Precision Converter

This block takes a wide word holding several signed two's-complement integers and turns each one into its IEEE-754 single-precision encoding. Each lane is converted on its own, and all lanes are converted in the same cycle. A single-precision significand holds 24 bits, so an integer whose magnitude needs more bits cannot be stored exactly. Such a lane is rounded under a 2-bit rounding-mode input, which is shared by all lanes.

A caller presents an operand with `valid_i` high. One clock later the packed result appears on `dst_o`, together with `valid_o` and an `inexact_o` flag. The flag is set when at least one lane had to round. The registered outputs keep their values until the next valid operand arrives. This block does not fetch operands, trap exceptions or mask them.

Top module: `pk_i2f_cvt`

## Requirements
- R1: Input lane i, bits [32i+31:32i], is converted into output lane i, bits [32i+31:32i]. No lane's value affects another lane's result.
- R2: Every integer whose magnitude is at most 2^24 converts exactly, and its inexact condition is clear. An input of 0 gives +0.0 (0x00000000).
- R3: The most negative input, 0x80000000, converts exactly to -2^31 (0xCF000000).
- R4: With rc_i = 2'b00 (nearest), an inexact lane goes to the closer representable value. An exact tie goes to the value with an even significand. Round-up carries may move into the exponent: 0x7FFFFFFF gives 0x4F000000.
- R5: With rc_i = 2'b01 (downward), an inexact lane goes to the next representable value toward minus infinity.
- R6: With rc_i = 2'b10 (upward), an inexact lane goes to the next representable value toward plus infinity.
- R7: With rc_i = 2'b11 (truncate), an inexact lane goes to the next representable value toward zero.
- R8: inexact_o is the OR of the per-lane conditions. A lane's condition is set when any magnitude bit below the kept 24-bit significand is nonzero.
- R9: valid_o equals valid_i delayed by exactly one clock. dst_o and inexact_o carry that operand's result in the same cycle as valid_o.
- R10: While valid_i is low, dst_o and inexact_o hold their previous values, whatever src_i and rc_i do.
- R11: While rst_ni is low, valid_o, dst_o and inexact_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand on src_i is valid this cycle |
| rc_i | input | 2 | Rounding mode: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| src_i | input | LANES*INT_W | Packed signed integer lanes |
| valid_o | output | 1 | Result valid |
| dst_o | output | LANES*32 | Packed single-precision results |
| inexact_o | output | 1 | At least one lane was rounded |

## Verification
The bench builds the block with its default parameters: four lanes and 32-bit integers. With four lanes, lane independence can be checked using a different value in every lane. With 32-bit lanes, up to eight magnitude bits fall below the significand. That range makes exact ties, sticky-only remainders and a round-up carry into the exponent all reachable under every rounding mode. The bench runs directed corner values and then several hundred random operands with random modes and gaps in valid_i. Every output is compared against a behavioural integer model on every clock.

// File: rtl/pk_i2f_pkg.sv
package pk_i2f_pkg;
  localparam int unsigned FP_W  = 32;
  localparam int unsigned EXP_W = 8;
  localparam int unsigned MAN_W = 23;
  localparam int unsigned BIAS  = 127;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/pk_i2f_lzc.sv
module pk_i2f_lzc #(
  parameter int unsigned W    = 32,
  parameter int unsigned CNT_W = $clog2(W)
) (
  input  logic [W-1:0]     val_i,
  output logic [CNT_W-1:0] cnt_o
);
  // highest set bit wins; all-zero input gives 0 (caller handles zero)
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      if (val_i[i]) cnt_o = CNT_W'(W - 1 - i);
    end
  end
endmodule

// File: rtl/pk_i2f_lane.sv
module pk_i2f_lane
  import pk_i2f_pkg::*;
#(
  parameter int unsigned INT_W = 32
) (
  input  logic [INT_W-1:0] src_i,
  input  rnd_mode_e        rc_i,
  output logic [FP_W-1:0]  res_o,
  output logic             inexact_o
);
  localparam int unsigned LZ_W = $clog2(INT_W);
  localparam int unsigned DROP = INT_W - 1 - MAN_W;   // bits below the significand

  logic             neg;
  logic [INT_W-1:0] mag, norm;
  logic [LZ_W-1:0]  lz;
  logic [MAN_W-1:0] frac;
  logic             rnd_bit, sticky, up, is_zero;
  logic [EXP_W-1:0] expo;
  logic [FP_W-2:0]  body, body_rnd;

  assign neg = src_i[INT_W-1];
  assign mag = neg ? (~src_i + 1'b1) : src_i;   // min int maps to 2^(W-1) unsigned

  pk_i2f_lzc #(.W(INT_W), .CNT_W(LZ_W)) u_lzc (
    .val_i (mag),
    .cnt_o (lz)
  );

  assign norm    = mag << lz;
  assign is_zero = ~norm[INT_W-1];
  assign frac    = norm[INT_W-2 -: MAN_W];
  assign rnd_bit = norm[DROP-1];
  assign sticky  = |norm[DROP-2:0];
  assign expo    = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz);

  assign inexact_o = ~is_zero & (rnd_bit | sticky);

  always_comb begin
    unique case (rc_i)
      RND_NEAR: up = rnd_bit & (sticky | frac[0]);
      RND_DOWN: up = neg & inexact_o;
      RND_UP:   up = ~neg & inexact_o;
      default:  up = 1'b0;
    endcase
  end

  // carry out of the fraction increments the exponent
  assign body     = {expo, frac};
  assign body_rnd = body + (FP_W-1)'(up);
  assign res_o    = is_zero ? '0 : {neg, body_rnd};
endmodule

// File: rtl/pk_i2f_cvt.sv
module pk_i2f_cvt
  import pk_i2f_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned INT_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [1:0]            rc_i,
  input  logic [LANES*INT_W-1:0] src_i,
  output logic                  valid_o,
  output logic [LANES*FP_W-1:0] dst_o,
  output logic                  inexact_o
);
  logic [LANES*FP_W-1:0] res_d;
  logic [LANES-1:0]      lane_inx;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pk_i2f_lane #(.INT_W(INT_W)) u_lane (
      .src_i     (src_i[l*INT_W +: INT_W]),
      .rc_i      (rnd_mode_e'(rc_i)),
      .res_o     (res_d[l*FP_W +: FP_W]),
      .inexact_o (lane_inx[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      dst_o     <= '0;
      inexact_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dst_o     <= res_d;
        inexact_o <= |lane_inx;
      end
    end
  end
endmodule

// File: rtl/pk_i2f_cvt_chk.sv
module pk_i2f_cvt_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned INT_W = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   valid_i,
  input logic [1:0]             rc_i,
  input logic [LANES*INT_W-1:0] src_i,
  input logic                   valid_o,
  input logic [LANES*32-1:0]    dst_o,
  input logic                   inexact_o
);
  localparam int unsigned HI = INT_W - 24;   // bits above a 24-bit signed range
  logic [LANES-1:0] lane_small;

  for (genvar l = 0; l < LANES; l++) begin : g_small
    logic [HI:0] top;
    assign top = src_i[l*INT_W + INT_W - 1 -: HI + 1];
    assign lane_small[l] = (top == '0) | (top == '1);

    // R1
    sign_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && src_i[l*INT_W +: INT_W] != '0) |=>
        dst_o[l*32 + 31] == $past(src_i[l*INT_W + INT_W - 1]));
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R9
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R10
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(dst_o) && $stable(inexact_o)));

  // R2
  zero_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && src_i == '0) |=> (dst_o == '0 && !inexact_o));

  // R8
  small_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && &lane_small) |=> !inexact_o);

  // R11
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (!valid_o && dst_o == '0 && !inexact_o);
    end
  end

  logic unused_rc;
  assign unused_rc = ^rc_i;
endmodule

bind pk_i2f_cvt pk_i2f_cvt_chk #(.LANES(LANES), .INT_W(INT_W)) u_chk (.*);

// File: tb/sim_pk_i2f_cvt.sv
`timescale 1ns/1ps
module sim_pk_i2f_cvt;
  localparam int LANES = 4;
  localparam int INT_W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [1:0] rc_i = 2'b00;
  logic [LANES*INT_W-1:0] src_i = '0;
  logic valid_o, inexact_o;
  logic [LANES*32-1:0] dst_o;

  always #5 clk = ~clk;

  pk_i2f_cvt #(.LANES(LANES), .INT_W(INT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .rc_i(rc_i), .src_i(src_i),
    .valid_o(valid_o), .dst_o(dst_o), .inexact_o(inexact_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_req = "R11";

  logic [LANES*32-1:0] exp_dst = '0;
  logic exp_inx = 1'b0;
  logic exp_vld = 1'b0;

  function automatic logic [31:0] ref_cvt(input logic [31:0] x, input logic [1:0] rc,
                                          output bit inex);
    longint v, m, q, r, half;
    bit neg, up;
    int e, sh;
    inex = 0;
    v = longint'(signed'(x));
    neg = v < 0;
    m = neg ? -v : v;
    if (m == 0) return 32'h0;
    e = 0;
    while ((m >> (e + 1)) != 0) e++;
    if (e <= 23) begin
      q = m << (23 - e);
    end else begin
      sh = e - 23;
      q = m >> sh;
      r = m - (q << sh);
      half = longint'(1) << (sh - 1);
      inex = (r != 0);
      case (rc)
        2'b00:   up = (r > half) || (r == half && q[0]);
        2'b01:   up = neg && inex;
        2'b10:   up = !neg && inex;
        default: up = 0;
      endcase
      if (up) q++;
      if (q == (longint'(1) << 24)) begin q = q >> 1; e++; end
    end
    return {neg, 8'(e + 127), q[22:0]};
  endfunction

  task automatic check_now();
    checks++;
    if (dst_o !== exp_dst || inexact_o !== exp_inx || valid_o !== exp_vld) begin
      fails++;
      $display("FAIL %s: dst=%h inx=%b vld=%b expected dst=%h inx=%b vld=%b",
               cur_req, dst_o, inexact_o, valid_o, exp_dst, exp_inx, exp_vld);
    end
  endtask

  // compare current outputs, then drive next operand and advance the model
  task automatic step(input bit v, input logic [1:0] rc, input logic [LANES*INT_W-1:0] s);
    bit inx_all, li;
    logic [LANES*32-1:0] d;
    @(negedge clk);
    check_now();
    valid_i = v; rc_i = rc; src_i = s;
    inx_all = 0;
    for (int l = 0; l < LANES; l++) begin
      d[l*32 +: 32] = ref_cvt(s[l*INT_W +: INT_W], rc, li);
      inx_all |= li;
    end
    exp_vld = v;
    if (v) begin exp_dst = d; exp_inx = inx_all; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R11";
    check_now();                                    // R11 reset state
    rst_ni = 1'b1;

    cur_req = "R2";                                 // R2 zero and small exact values
    step(1, 2'b00, '0);
    step(1, 2'b01, {32'd1, 32'hFFFFFFFF, 32'd16777216, 32'hFF000000});
    step(1, 2'b10, {32'd16777215, 32'd12345, 32'hFFFFFF85, 32'd7});
    cur_req = "R3";                                 // R3 most negative input
    step(1, 2'b11, {32'h80000000, 32'h80000000, 32'd0, 32'h80000000});
    cur_req = "R1";                                 // R1 distinct lanes
    step(1, 2'b00, {32'h12345678, 32'hFEDCBA98, 32'd0, 32'd3});
    step(1, 2'b00, {32'd0, 32'd0, 32'h7FFFFFF5, 32'd0});
    cur_req = "R4";                                 // R4 ties and exponent carry
    step(1, 2'b00, {32'h01000001, 32'h01000003, 32'hFEFFFFFF, 32'h7FFFFFFF});
    step(1, 2'b00, {32'h7FFFFF80, 32'h7FFFFFC0, 32'h80000001, 32'h02000002});
    cur_req = "R5";                                 // R5 downward
    step(1, 2'b01, {32'h01000001, 32'hFEFFFFFF, 32'h7FFFFFFF, 32'h80000001});
    cur_req = "R6";                                 // R6 upward
    step(1, 2'b10, {32'h01000001, 32'hFEFFFFFF, 32'h7FFFFFFF, 32'h80000001});
    cur_req = "R7";                                 // R7 truncate
    step(1, 2'b11, {32'h01000001, 32'hFEFFFFFF, 32'h7FFFFFFF, 32'h80000001});
    cur_req = "R8";                                 // R8 one inexact lane sets flag
    step(1, 2'b00, {32'd5, 32'd6, 32'd7, 32'h01000001});
    step(1, 2'b00, {32'd5, 32'd6, 32'd7, 32'h01000002});
    cur_req = "R10";                                // R10 hold while idle
    step(0, 2'b10, {32'hFFFFFFFF, 32'h7FFFFFFF, 32'h0, 32'h01000001});
    step(0, 2'b01, {32'h0, 32'h0, 32'h0, 32'h0});
    cur_req = "R9";                                 // R9 back-to-back and gaps
    step(1, 2'b00, {32'd1, 32'd2, 32'd3, 32'd4});
    step(1, 2'b11, {32'd9, 32'd8, 32'd7, 32'd6});
    step(0, 2'b00, '0);
    step(1, 2'b10, {32'h40000001, 32'd0, 32'd0, 32'd0});

    cur_req = "R4-R7/R9 random";
    for (int n = 0; n < 600; n++) begin
      logic [LANES*INT_W-1:0] s;
      for (int l = 0; l < LANES; l++) begin
        logic [31:0] w;
        w = $urandom;
        case ($urandom_range(0, 3))
          0: w = w >> $urandom_range(0, 31);
          1: w = $signed(w) >>> $urandom_range(0, 31);
          default: ;
        endcase
        s[l*INT_W +: INT_W] = w;
      end
      step(($urandom_range(0, 4) != 0), 2'($urandom_range(0, 3)), s);
    end
    step(0, 2'b00, '0);
    step(0, 2'b00, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule